// File: doc/BRIEF.md
# Cross-Domain Init Mode Handshake

This block moves a peripheral between normal operation and initialization mode when its register side and its bus-protocol side are clocked from two unrelated sources. A host in the register clock domain writes a request bit. The bit crosses into the protocol clock domain through a synchronizer. The protocol side enters init mode once any frame in flight has finished. It then returns an acknowledge level through a second synchronizer, and the host reads that level as a flag. Leaving init mode follows the same path in reverse.

The register side is a four-state machine. RUN means request 0 and flag 0. ENTER means request 1 and flag 0. INIT means request 1 and flag 1. LEAVE means request 0 and flag 1. Its transitions are named:
- start_entry (RUN to ENTER, on a write of 1)
- entry_done (ENTER to INIT, when the flag rises)
- start_exit (INIT to LEAVE, on a write of 0; it is also taken from ENTER when the flag rises in the same cycle as a write of 0)
- exit_done (LEAVE to RUN, when the flag falls)

The protocol side has three states: ACTIVE, DRAIN and HALTED. Its transitions are named:
- req_seen_idle (ACTIVE to HALTED)
- req_seen_busy (ACTIVE to DRAIN)
- drain_done (DRAIN to HALTED, when the frame ends)
- release (HALTED to ACTIVE, when the synchronized request drops)

While the protocol side is HALTED, `init_active` is high. This holds the protocol engine in reset and blocks new frames from starting.

Top module: `init_mode_handshake`

## Requirements
- R1: A host write with `wr_data`=1 while the request is 0 and the flag is 0 sets `host_req` to 1 on the next `clk_reg` edge.
- R2: `host_ack` rises only after `init_active` has risen, so the flag reads 1 only when both domains are in init mode.
- R3: With `frame_busy` low, `init_active` rises on the 3rd `clk_proto` edge after `host_req` rises. `host_ack` then rises on the 2nd `clk_reg` edge after that.
- R4: While the request is 1 and the flag is 0, a write with `wr_data`=0 is ignored and `host_req` stays 1.
- R5: While the request is 1 and the flag is 1, a write with `wr_data`=0 clears `host_req` on the next `clk_reg` edge.
- R6: While `frame_busy` is high, the protocol side does not enter init mode and `init_active` stays 0. Once `frame_busy` is low, `init_active` rises on the next `clk_proto` edge.
- R7: Exit mirrors entry. `init_active` falls on the 3rd `clk_proto` edge after `host_req` falls, and `host_ack` falls on the 2nd `clk_reg` edge after that.
- R8: While in init mode, `init_active` stays 1 whatever `frame_busy` does, until the request is withdrawn.
- R9: While the request is 0 and the flag is still 1, a write with `wr_data`=1 is ignored and `host_req` stays 0.
- R10: After reset, `host_req`, `host_ack` and `init_active` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Register-domain clock |
| clk_proto | input | 1 | Protocol-domain clock, unrelated to clk_reg |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Host write strobe for the request bit (clk_reg) |
| wr_data | input | 1 | Value written to the request bit: 1 asks for init mode, 0 asks to leave it |
| frame_busy | input | 1 | High while the protocol engine is moving a frame (clk_proto) |
| host_req | output | 1 | Current request bit as seen by the host |
| host_ack | output | 1 | Init acknowledge flag, synchronized into clk_reg |
| init_active | output | 1 | Protocol-domain init mode; holds the engine in reset and blocks frame starts |

## Verification
The host request is due one `clk_reg` edge after a write. The bench's behavioural model predicts it from the write and the flag value before that edge, and compares it 1 ns after every `clk_reg` edge. The protocol result is due on the 3rd `clk_proto` edge after a request change. The flag is due on the 2nd `clk_reg` edge after that. The bench counts the edges of each clock between the change and its effect, and the two clocks have phases that never coincide, so each count is exact. A drain is checked by holding `frame_busy` for twenty protocol edges. The bench then expects `init_active` one protocol edge after `frame_busy` is released.

// File: rtl/init_hs_pkg.sv
package init_hs_pkg;
    typedef enum logic [1:0] {
        H_RUN   = 2'd0,
        H_ENTER = 2'd1,
        H_INIT  = 2'd2,
        H_LEAVE = 2'd3
    } host_state_t;

    typedef enum logic [1:0] {
        P_ACTIVE = 2'd0,
        P_DRAIN  = 2'd1,
        P_HALTED = 2'd2
    } proto_state_t;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/init_host_fsm.sv
module init_host_fsm
    import init_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_data,
    input  logic ack_s,
    output logic req_o
);
    host_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= H_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_RUN:   if (wr_en && wr_data) state_d = H_ENTER;
            H_ENTER: if (ack_s) state_d = (wr_en && !wr_data) ? H_LEAVE : H_INIT;
            H_INIT:  if (wr_en && !wr_data) state_d = H_LEAVE;
            H_LEAVE: if (!ack_s) state_d = (wr_en && wr_data) ? H_ENTER : H_RUN;
            default: state_d = H_INIT;
        endcase
    end

    always_comb begin
        req_o = (state_q == H_ENTER) || (state_q == H_INIT);
    end

    // R4
    clear_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_s && wr_en && !wr_data) |=> req_o);

    // R9
    set_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && ack_s && wr_en && wr_data) |=> !req_o);
endmodule

// File: rtl/init_proto_fsm.sv
module init_proto_fsm
    import init_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic frame_busy,
    output logic ack_o,
    output logic init_active
);
    proto_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_ACTIVE: if (req_s) state_d = frame_busy ? P_DRAIN : P_HALTED;
            P_DRAIN:  if (!frame_busy) state_d = P_HALTED;
            P_HALTED: if (!req_s) state_d = P_ACTIVE;
            default:  state_d = P_HALTED;
        endcase
    end

    always_comb begin
        init_active = (state_q == P_HALTED);
        ack_o       = (state_q == P_HALTED);
    end

    // R6
    busy_blocks_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_active && frame_busy) |=> !init_active);

    // R8
    init_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_active && req_s) |=> init_active);

    // R2
    entry_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(req_s));
endmodule

// File: rtl/init_mode_handshake.sv
module init_mode_handshake #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_reg,
    input  logic clk_proto,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_data,
    input  logic frame_busy,
    output logic host_req,
    output logic host_ack,
    output logic init_active
);
    logic req_s;
    logic ack_p;

    init_host_fsm u_host (
        .clk     (clk_reg),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ack_s   (host_ack),
        .req_o   (host_req)
    );

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
        .clk   (clk_proto),
        .rst_n (rst_n),
        .d     (host_req),
        .q     (req_s)
    );

    init_proto_fsm u_proto (
        .clk         (clk_proto),
        .rst_n       (rst_n),
        .req_s       (req_s),
        .frame_busy  (frame_busy),
        .ack_o       (ack_p),
        .init_active (init_active)
    );

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
        .clk   (clk_reg),
        .rst_n (rst_n),
        .d     (ack_p),
        .q     (host_ack)
    );

    // R2
    flag_after_init_chk: assert property (@(posedge clk_reg) disable iff (!rst_n)
        $rose(host_ack) |-> init_active);
endmodule

// File: tb/tb_init_mode_handshake.sv
module tb_init_mode_handshake;
    logic clk_reg = 1'b0;
    logic clk_proto = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic wr_data = 1'b0;
    logic frame_busy = 1'b0;
    logic host_req, host_ack, init_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int pcount = 0;
    int rcount = 0;
    int p_at_req = 0;
    int p_lat = 0;
    int r_at_init = 0;
    int r_lat = 0;
    logic exp_req = 1'b1;
    logic prev_req = 1'b1;
    logic prev_init = 1'b1;
    logic prev_ack = 1'b1;

    init_mode_handshake dut (
        .clk_reg     (clk_reg),
        .clk_proto   (clk_proto),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .frame_busy  (frame_busy),
        .host_req    (host_req),
        .host_ack    (host_ack),
        .init_active (init_active)
    );

    always #10 clk_reg = ~clk_reg;
    initial begin
        #7;
        forever #15 clk_proto = ~clk_proto;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model for the host request bit, updated from pre-edge values.
    always @(posedge clk_reg) begin
        rcount++;
        if (!rst_n) begin
            exp_req = 1'b1;
        end else if (wr_en) begin
            if (wr_data && !(!exp_req && host_ack)) exp_req = 1'b1;
            else if (!wr_data && exp_req && host_ack) exp_req = 1'b0;
        end
        #1;
        if (rst_n) chk("R1/R4/R5/R9 host_req per-clock", host_req, exp_req);
        if (host_req !== prev_req) p_at_req = pcount;
        if (host_ack !== prev_ack) r_lat = rcount - r_at_init;
        prev_req = host_req;
        prev_ack = host_ack;
    end

    always @(posedge clk_proto) begin
        pcount++;
        #1;
        if (init_active !== prev_init) begin
            p_lat = pcount - p_at_req;
            r_at_init = rcount;
        end
        prev_init = init_active;
    end

    task automatic host_write(input logic v);
        @(negedge clk_reg);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk_reg);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk_reg);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk_reg);
        rst_n = 1'b1;
        @(negedge clk_reg);
        // R10 reset state
        chk("R10 host_req", host_req, 1);
        chk("R10 host_ack", host_ack, 1);
        chk("R10 init_active", init_active, 1);

        // R5 / R7: leave init mode
        host_write(1'b0);
        chk("R5 host_req cleared", host_req, 0);
        wait (host_ack == 1'b0);
        @(negedge clk_reg);
        chk("R7 exit proto latency", p_lat, 3);
        chk("R7 exit reg latency", r_lat, 2);
        chk("R7 init_active low", init_active, 0);

        // R1 / R3 / R4: enter while idle, clear attempt ignored
        @(negedge clk_reg);
        wr_en = 1'b1; wr_data = 1'b1;
        @(negedge clk_reg);
        chk("R1 host_req set", host_req, 1);
        wr_data = 1'b0;
        @(negedge clk_reg);
        wr_en = 1'b0;
        chk("R4 clear ignored", host_req, 1);
        chk("R2 flag still low", host_ack, 0);
        wait (host_ack == 1'b1);
        @(negedge clk_reg);
        chk("R3 entry proto latency", p_lat, 3);
        chk("R3 entry reg latency", r_lat, 2);
        chk("R2 init_active with flag", init_active, 1);

        // R8: busy while in init mode has no effect
        @(negedge clk_proto);
        frame_busy = 1'b1;
        repeat (5) @(negedge clk_proto);
        chk("R8 init_active held", init_active, 1);
        frame_busy = 1'b0;

        // R9: set during leave phase ignored
        @(negedge clk_reg);
        wr_en = 1'b1; wr_data = 1'b0;
        @(negedge clk_reg);
        wr_data = 1'b1;
        @(negedge clk_reg);
        wr_en = 1'b0;
        chk("R9 set ignored", host_req, 0);
        chk("R9 flag still high", host_ack, 1);
        wait (host_ack == 1'b0);
        @(negedge clk_reg);
        chk("R9 request stays low", host_req, 0);
        chk("R7 exit proto latency 2", p_lat, 3);

        // R6: entry postponed while a frame is busy
        @(negedge clk_proto);
        frame_busy = 1'b1;
        host_write(1'b1);
        repeat (20) @(negedge clk_proto);
        chk("R6 init_active held off", init_active, 0);
        chk("R6 flag held off", host_ack, 0);
        frame_busy = 1'b0;
        @(posedge clk_proto);
        #1;
        chk("R6 init after drain", init_active, 1);
        wait (host_ack == 1'b1);
        @(negedge clk_reg);
        chk("R6 drain reg latency", r_lat, 2);
        chk("R6 request held", host_req, 1);

        repeat (4) @(negedge clk_reg);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule